// File: doc/BRIEF.md
# Arbiter Delay-Race Response Core

This block is a cycle-based digital model of a delay-race identification function. A chain of switch stages carries two edges launched together. Each challenge bit controls one stage. A 0 keeps both edges on their positions. A 1 swaps them. Each stage charges the edge passing through it a delay that depends on the stage, on the edge's current position (upper or lower) and on the setting. These small integers are loaded through a write port before evaluation. They stand in for the mismatch of one manufactured instance. At the end of the chain an arbiter decides which output position the first edge reached and returns one response bit.

Two otherwise identical cores loaded with different delay sets give different responses to the same challenge. One core with a fixed delay set always gives the same response to the same challenge. The walk is serial: the controller adds one stage per clock into two arrival totals, then compares them.

Controller states: `S_IDLE` waits for a start strobe (IDLE→ROUTE on an accepted start). `S_ROUTE` processes one stage per cycle (ROUTE→JUDGE after the last stage). `S_JUDGE` compares the two totals and registers the result (JUDGE→IDLE always).

Top module: `arb_puf_core`

## Requirements
- R1: After reset `resp`, `tie`, `done` and `busy` are all 0.
- R2: A write with `cfg_we` high in idle stores `cfg_data` as the delay of stage `cfg_stage`. `cfg_sel[1]` picks the position (0 upper, 1 lower) and `cfg_sel[0]` picks the setting (0 straight, 1 crossed). The encoding is 0 upper-straight, 1 upper-crossed, 2 lower-straight, 3 lower-crossed. Stored delays are 0 after reset.
- R3: Stage i is steered by challenge bit i. At that stage each edge is charged the delay stored for (i, its current position, bit i). A bit of 1 moves each edge to the other position, and a bit of 0 leaves both in place.
- R4: `resp` is 1 when the total delay of the edge leaving at the upper position is smaller than that of the edge leaving at the lower position. It is 0 when the upper total is larger.
- R5: When both totals are equal, `resp` is 0 and `tie` is 1. Otherwise `tie` is 0.
- R6: A start sampled in idle makes `busy` high from the next cycle. `done` is high for exactly one cycle, seen STAGES+1 clock edges after the start edge, and `busy` is low in that cycle. The challenge is captured at the start edge.
- R7: A start strobe while busy is ignored. The run is not restarted and its challenge is not replaced.
- R8: A configuration write while busy is ignored and leaves the stored delays unchanged.
- R9: The same challenge on an unchanged delay set always gives the same `resp` and `tie`.
- R10: `resp` and `tie` hold their values in every cycle except the one where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Delay write strobe |
| cfg_stage | input | $clog2(STAGES) | Stage index of the write |
| cfg_sel | input | 2 | {position, setting} of the written delay |
| cfg_data | input | DLY_W | Delay value |
| chal | input | STAGES | Challenge vector, bit i steers stage i |
| start | input | 1 | Launch strobe |
| resp | output | 1 | Arbiter decision |
| tie | output | 1 | Both edges arrived together |
| done | output | 1 | One-cycle result-valid pulse |
| busy | output | 1 | Evaluation in progress |

## Verification
The bench aims at the equal-arrival case. A design that broke ties toward 1, or never raised `tie`, would report a winner where none exists. Single-stage delay patterns check that a crossed stage moves the edge and charges the crossed value. A design that charged the wrong position or ignored the swap would give the wrong winner. Strobes and delay writes are injected in the middle of a run. A design that restarted would pulse `done` late, and one that accepted the write would turn a known tie into a decision. Every clock is compared against a reference count of `busy` and `done`, so a one-cycle latency error is caught at once.

// File: rtl/arb_race_pkg.sv
package arb_race_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ROUTE = 2'd1,
        S_JUDGE = 2'd2
    } race_state_t;
endpackage

// File: rtl/arb_delay_bank.sv
module arb_delay_bank #(
    parameter int STAGES = 64,
    parameter int DLY_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(STAGES)-1:0] wr_stage,
    input  logic [1:0]                wr_sel,
    input  logic [DLY_W-1:0]          wr_data,
    input  logic [$clog2(STAGES)-1:0] rd_stage,
    output logic [DLY_W-1:0]          up_straight,
    output logic [DLY_W-1:0]          up_crossed,
    output logic [DLY_W-1:0]          lo_straight,
    output logic [DLY_W-1:0]          lo_crossed
);
    localparam int IDX_W = $clog2(STAGES);

    logic [4*DLY_W-1:0] stage_word [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [DLY_W-1:0] slot [4];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < 4; k++) slot[k] <= '0;
            end else if (wr_en && (wr_stage == IDX_W'(s))) begin
                slot[wr_sel] <= wr_data;
            end
        end
        assign stage_word[s] = {slot[3], slot[2], slot[1], slot[0]};
    end

    logic [4*DLY_W-1:0] rd_word;
    assign rd_word     = stage_word[rd_stage];
    assign up_straight = rd_word[0*DLY_W +: DLY_W];
    assign up_crossed  = rd_word[1*DLY_W +: DLY_W];
    assign lo_straight = rd_word[2*DLY_W +: DLY_W];
    assign lo_crossed  = rd_word[3*DLY_W +: DLY_W];
endmodule

// File: rtl/arb_race_accum.sv
module arb_race_accum #(
    parameter int DLY_W = 4,
    parameter int SUM_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             steer,
    input  logic [DLY_W-1:0] up_straight,
    input  logic [DLY_W-1:0] up_crossed,
    input  logic [DLY_W-1:0] lo_straight,
    input  logic [DLY_W-1:0] lo_crossed,
    output logic [SUM_W-1:0] up_time,
    output logic [SUM_W-1:0] lo_time
);
    // edge A launched at the upper position, edge B at the lower
    logic [SUM_W-1:0] sum_a, sum_b;
    logic             a_low;
    logic [DLY_W-1:0] cost_up, cost_lo;

    assign cost_up = steer ? up_crossed : up_straight;
    assign cost_lo = steer ? lo_crossed : lo_straight;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum_a <= '0;
            sum_b <= '0;
            a_low <= 1'b0;
        end else if (step) begin
            sum_a <= sum_a + SUM_W'(a_low ? cost_lo : cost_up);
            sum_b <= sum_b + SUM_W'(a_low ? cost_up : cost_lo);
            a_low <= a_low ^ steer;
        end
    end

    assign up_time = a_low ? sum_b : sum_a;
    assign lo_time = a_low ? sum_a : sum_b;

    // R3: totals only ever grow while stages are walked
    assert_sum_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (sum_a >= $past(sum_a)) && (sum_b >= $past(sum_b)));
endmodule

// File: rtl/arb_judge.sv
module arb_judge #(
    parameter int SUM_W = 11
) (
    input  logic [SUM_W-1:0] up_time,
    input  logic [SUM_W-1:0] lo_time,
    output logic             win_up,
    output logic             dead_heat
);
    always_comb begin
        dead_heat = (up_time == lo_time);
        win_up    = (up_time < lo_time);
        // R5: an equal arrival never reports the upper path as winner
        assert_tie_clears_resp_R5: assert (!(dead_heat && win_up));
    end
endmodule

// File: rtl/arb_puf_core.sv
module arb_puf_core
    import arb_race_pkg::*;
#(
    parameter int STAGES = 64,
    parameter int DLY_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [$clog2(STAGES)-1:0] cfg_stage,
    input  logic [1:0]                cfg_sel,
    input  logic [DLY_W-1:0]          cfg_data,
    input  logic [STAGES-1:0]         chal,
    input  logic                      start,
    output logic                      resp,
    output logic                      tie,
    output logic                      done,
    output logic                      busy
);
    localparam int IDX_W = $clog2(STAGES);
    localparam int SUM_W = DLY_W + IDX_W + 1;

    race_state_t       state_q, state_d;
    logic [IDX_W-1:0]  stage_q;
    logic [STAGES-1:0] chal_q;
    logic              accept, last_stage;
    logic [DLY_W-1:0]  d_us, d_ux, d_ls, d_lx;
    logic [SUM_W-1:0]  t_up, t_lo;
    logic              win_up, dead_heat;
    logic              resp_q, tie_q, done_q;

    assign accept     = (state_q == S_IDLE) && start;
    assign last_stage = (stage_q == IDX_W'(STAGES - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_ROUTE;
            S_ROUTE: if (last_stage) state_d = S_JUDGE;
            S_JUDGE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            chal_q  <= '0;
        end else if (accept) begin
            stage_q <= '0;
            chal_q  <= chal;
        end else if (state_q == S_ROUTE) begin
            stage_q <= stage_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= 1'b0;
            tie_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == S_JUDGE);
            if (state_q == S_JUDGE) begin
                resp_q <= win_up;
                tie_q  <= dead_heat;
            end
        end
    end

    arb_delay_bank #(.STAGES(STAGES), .DLY_W(DLY_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we && (state_q == S_IDLE)),
        .wr_stage    (cfg_stage),
        .wr_sel      (cfg_sel),
        .wr_data     (cfg_data),
        .rd_stage    (stage_q),
        .up_straight (d_us),
        .up_crossed  (d_ux),
        .lo_straight (d_ls),
        .lo_crossed  (d_lx)
    );

    arb_race_accum #(.DLY_W(DLY_W), .SUM_W(SUM_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .step        (state_q == S_ROUTE),
        .steer       (chal_q[stage_q]),
        .up_straight (d_us),
        .up_crossed  (d_ux),
        .lo_straight (d_ls),
        .lo_crossed  (d_lx),
        .up_time     (t_up),
        .lo_time     (t_lo)
    );

    arb_judge #(.SUM_W(SUM_W)) u_judge (
        .up_time   (t_up),
        .lo_time   (t_lo),
        .win_up    (win_up),
        .dead_heat (dead_heat)
    );

    assign resp = resp_q;
    assign tie  = tie_q;
    assign done = done_q;
    assign busy = (state_q != S_IDLE);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(chal_q));
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(resp) && $stable(tie)));
endmodule

// File: tb/sim_arb_puf_core.sv
`timescale 1ns/1ps
module sim_arb_puf_core;
    localparam int STAGES = 64;
    localparam int DLY_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [5:0]        cfg_stage = '0;
    logic [1:0]        cfg_sel = '0;
    logic [DLY_W-1:0]  cfg_data = '0;
    logic [STAGES-1:0] chal = '0;
    logic              start = 1'b0;
    logic              resp, tie, done, busy;

    int n_checks = 0;
    int n_fail   = 0;
    int model [STAGES][4];

    always #2 clk = ~clk;

    arb_puf_core #(.STAGES(STAGES), .DLY_W(DLY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stage(cfg_stage),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .chal(chal), .start(start),
        .resp(resp), .tie(tie), .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int st, input int sel, input int val);
        cfg_we = 1'b1; cfg_stage = 6'(st); cfg_sel = 2'(sel); cfg_data = DLY_W'(val);
        model[st][sel] = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_fill(input bit rnd, input int val);
        for (int s = 0; s < STAGES; s++)
            for (int k = 0; k < 4; k++)
                cfg_write(s, k, rnd ? int'($urandom_range(15, 0)) : val);
    endtask

    // behavioural race: follow each launched edge, add the delay for its position
    function automatic void race(input logic [STAGES-1:0] c, output int up, output int lo);
        int ta = 0, tb = 0;
        int pa = 0;
        for (int i = 0; i < STAGES; i++) begin
            int sel_a = pa * 2 + int'(c[i]);
            int sel_b = (1 - pa) * 2 + int'(c[i]);
            ta += model[i][sel_a];
            tb += model[i][sel_b];
            if (c[i]) pa = 1 - pa;
        end
        up = (pa == 0) ? ta : tb;
        lo = (pa == 0) ? tb : ta;
    endfunction

    // R3 R4 R5 R6 R7 R8 R10: one evaluation, busy/done compared on every clock
    task automatic run(input logic [STAGES-1:0] c, input bit inj_start, input bit inj_cfg,
                       input string req, output bit r_out, output bit t_out);
        int up, lo;
        bit er, et;
        race(c, up, lo);
        et = (up == lo);
        er = (up < lo);
        chal = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0; chal = ~c;
        chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
        chk(done == 1'b0, "R6 no early done", int'(done), 0);
        for (int k = 1; k <= STAGES; k++) begin
            if (inj_start && k == 10) begin start = 1'b1; chal = ~c; end
            if (inj_cfg && k >= 20 && k < 22) begin
                cfg_we = 1'b1; cfg_stage = 6'(STAGES - 1); cfg_sel = 2'(k - 20); cfg_data = '1;
            end
            @(negedge clk);
            start = 1'b0; cfg_we = 1'b0;
            chk(busy == 1'b1, inj_start ? "R7 busy mid run" : "R6 busy mid run", int'(busy), 1);
            chk(done == 1'b0, inj_start ? "R7 no early done" : "R6 no early done", int'(done), 0);
        end
        @(negedge clk);
        chk(done == 1'b1, "R6 done at STAGES+1", int'(done), 1);
        chk(busy == 1'b0, "R6 idle in done cycle", int'(busy), 0);
        chk(resp == er, req, int'(resp), int'(er));
        chk(tie == et, et ? "R5 tie flag" : "R5 no tie", int'(tie), int'(et));
        r_out = resp; t_out = tie;
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
        chk(resp == er && tie == et, "R10 result held", int'({resp, tie}), int'({er, et}));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit r1, t1, r2, t2;
        logic [STAGES-1:0] c;
        for (int s = 0; s < STAGES; s++) for (int k = 0; k < 4; k++) model[s][k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(resp == 0 && tie == 0, "R1 reset result", int'({resp, tie}), 0);
        chk(done == 0 && busy == 0, "R1 reset control", int'({done, busy}), 0);

        // R2 R5: reset delays are zero, so any challenge is a dead heat
        run(64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, "R2 zero delays after reset", r1, t1);
        chk(t1 == 1'b1, "R5 zero delays tie", int'(t1), 1);
        // R8: writes during the run must not break the tie
        run('0, 1'b0, 1'b1, "R8 write while busy", r1, t1);
        chk(t1 == 1'b1 && r1 == 1'b0, "R8 tie kept", int'({r1, t1}), 1);
        run('0, 1'b0, 1'b0, "R8 delays unchanged", r1, t1);
        chk(t1 == 1'b1, "R8 tie persists", int'(t1), 1);

        // R2 R3 R4: directed single-stage patterns
        cfg_write(0, 1, 3);        // stage0 upper crossed
        run(64'h1, 1'b0, 1'b0, "R3 crossed edge charged", r1, t1);
        chk(r1 == 1'b1, "R4 upper wins", int'(r1), 1);
        run(64'h0, 1'b0, 1'b0, "R3 straight ignores crossed value", r1, t1);
        cfg_write(5, 2, 7);        // stage5 lower straight
        run(64'h0, 1'b0, 1'b0, "R4 lower slower", r1, t1);
        run(64'h20, 1'b0, 1'b0, "R3 crossed stage5 skips straight value", r1, t1);
        run(64'h1, 1'b0, 1'b0, "R3 swapped edge charged at new position", r1, t1);
        cfg_write(2, 0, 9);        // stage2 upper straight
        run(64'h0, 1'b0, 1'b0, "R4 upper slower gives 0", r1, t1);
        chk(r1 == 1'b0 && t1 == 1'b0, "R4 lower wins", int'({r1, t1}), 0);

        // R4 R7 R9: random instances and challenges
        for (int cfgn = 0; cfgn < 3; cfgn++) begin
            cfg_fill(1'b1, 0);
            for (int j = 0; j < 5; j++) begin
                c = {$urandom, $urandom};
                run(c, 1'b0, 1'b0, "R4 random response", r1, t1);
                run(c, (j == 0), 1'b0, (j == 0) ? "R7 start ignored" : "R9 repeat", r2, t2);
                chk(r1 == r2 && t1 == t2, "R9 repeatable", int'({r2, t2}), int'({r1, t1}));
            end
        end

        // R5: uniform delays give equal totals for every challenge
        cfg_fill(1'b0, 5);
        run({$urandom, $urandom}, 1'b0, 1'b0, "R5 uniform tie resp 0", r1, t1);
        chk(t1 == 1'b1 && r1 == 1'b0, "R5 uniform tie", int'({r1, t1}), 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule